// File: doc/BRIEF.md
# Cascaded Display Memory Address Sequencer

This block generates the memory address for each data byte that crosses the serial bus into or out of a banked display memory. The memory has four banks. Each bank holds forty column bytes, and each byte carries eight vertical pixels of one column. Several identical driver chips can share one bus and one byte stream. Each chip holds a copy of this sequencer and a four-bit subaddress strapped on its pins. The sequencers advance in lockstep, and only the chip whose subaddress counter equals its strap actually stores or returns a byte.

The bus controller issues three kinds of command:
- a device-select command loads the subaddress counter;
- a column command loads the X (column-byte) position;
- a memory-access command loads the starting bank and the walk order.

After that, each byte strobe uses the current pointer and then advances it. The walk order is one of three:
- a linear walk across columns and then banks;
- a paired walk that visits two adjacent banks per column;
- a tiled walk that writes 8-column glyph cells one bank at a time.

When the walk runs past the last location of one chip, the subaddress counter steps on so that the stream continues in the next chip. After 15 the counter returns to 0.

Top module: `disp_addr_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `cur_sub`, `cur_x` and `cur_bank` are 0, the walk order is linear, and `wr_en` and `rd_valid` are 0 while no strobe is given.
- R2: A command pulse loads its field at the next clock edge.
  - `ld_sub` loads `sub_val`.
  - `ld_x` loads `x_val`, saturated to 39.
  - `ld_ram` loads `bank_val` and `mode_val`.
  - Any load restarts the paired and tiled walks at the loaded point, and a load takes priority over a byte strobe in the same cycle.
- R3: Linear order (`mode_val` = 2'b10): X steps 0 to 39. After 39, X returns to 0 and the bank steps. After bank 3, the bank returns to 0 and the subaddress steps.
- R4: Paired order (`mode_val` = 2'b01): each column takes two bytes, bank b then bank (b+1) mod 4, and then X steps. After X = 39, X returns to 0 and the pair base moves up by two. If the base passes bank 3, it wraps by 4 and the subaddress steps.
- R5: Tiled order (`mode_val` = 2'b00): one bank receives 8 consecutive columns starting at the cell base, or fewer if column 39 is reached first. The walk then moves to the next bank at the cell base. After bank 3 it moves to bank 0 at base+8. A base of 40 or more becomes 0 and the subaddress steps.
- R6: The subaddress counter moves only by a load or by +1 at the end of a chip's range, and it wraps from 15 to 0.
- R7: `wr_en` equals `byte_stb & byte_wr` in the same cycle, and `rd_valid` equals `byte_stb & !byte_wr` in the same cycle, both only while `cur_sub` equals `pin_sub`.
- R8: Every byte strobe without a load advances the pointer, whether or not the subaddresses match.
- R9: The mode code 2'b11 walks exactly as the linear order.
- R10: `mem_addr` always equals `cur_bank*40 + cur_x`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_sub | input | 4 | Strapped hardware subaddress |
| ld_sub | input | 1 | Device-select command strobe |
| sub_val | input | 4 | Subaddress to load |
| ld_x | input | 1 | Column command strobe |
| x_val | input | 6 | Column position to load |
| ld_ram | input | 1 | Memory-access command strobe |
| bank_val | input | 2 | Starting bank to load |
| mode_val | input | 2 | Walk order: 00 tiled, 01 paired, 10 linear, 11 linear |
| byte_stb | input | 1 | One data byte transferred this cycle |
| byte_wr | input | 1 | 1 = byte is a write, 0 = a read |
| cur_sub | output | 4 | Subaddress counter |
| cur_x | output | 6 | Current column position |
| cur_bank | output | 2 | Current bank |
| mem_addr | output | 8 | Linear memory address, bank*40 + X |
| dev_sel | output | 1 | Subaddress counter equals `pin_sub` |
| wr_en | output | 1 | Store the byte at `mem_addr` |
| rd_valid | output | 1 | Return the byte at `mem_addr` |

## Verification
The enables `wr_en` and `rd_valid` and the address `mem_addr` are combinational. They are due in the same cycle as the strobe and are taken from the pointer as it stood before that cycle's edge. Pointer fields and loads take effect one edge after the cycle in which they are presented. The bench drives inputs on the falling edge and compares shortly after it. Its reference model updates only at the rising edge, so both timings are compared every cycle. The walks are run across chip boundaries, including the wrap from 15 to 0, with strap mismatches on both sides.

// File: rtl/dap_pkg.sv
package dap_pkg;

    typedef enum logic [1:0] {
        WALK_TILE = 2'b00,
        WALK_PAIR = 2'b01,
        WALK_LIN  = 2'b10
    } walk_e;

    // Code 2'b11 has no walk of its own and is folded onto the linear order.
    function automatic walk_e decode_walk(input logic [1:0] code);
        case (code)
            2'b00:   return WALK_TILE;
            2'b01:   return WALK_PAIR;
            default: return WALK_LIN;
        endcase
    endfunction

endpackage

// File: rtl/dap_gate.sv
module dap_gate #(
    parameter int SUBW = 4
) (
    input  logic [SUBW-1:0] pin_sub,
    input  logic [SUBW-1:0] cur_sub,
    input  logic            byte_stb,
    input  logic            byte_wr,
    output logic            dev_sel,
    output logic            wr_en,
    output logic            rd_valid
);
    always_comb begin
        dev_sel  = (pin_sub == cur_sub);
        wr_en    = dev_sel & byte_stb & byte_wr;
        rd_valid = dev_sel & byte_stb & ~byte_wr;
    end
endmodule

// File: rtl/dap_ptr.sv
module dap_ptr
    import dap_pkg::*;
#(
    parameter int NCOL  = 40,
    parameter int NBANK = 4,
    parameter int SUBW  = 4,
    parameter int GRP   = 8,
    localparam int XW   = $clog2(NCOL),
    localparam int BW   = $clog2(NBANK)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ld_sub,
    input  logic [SUBW-1:0] sub_val,
    input  logic            ld_x,
    input  logic [XW-1:0]   x_val,
    input  logic            ld_ram,
    input  logic [BW-1:0]   bank_val,
    input  logic [1:0]      mode_val,
    input  logic            adv,
    output logic [SUBW-1:0] sub_o,
    output logic [XW-1:0]   x_o,
    output logic [BW-1:0]   bank_o
);
    localparam logic [XW-1:0] XLAST = XW'(NCOL - 1);
    localparam logic [BW-1:0] BLAST = BW'(NBANK - 1);

    typedef struct packed {
        logic [SUBW-1:0] sub;
        logic [XW-1:0]   x;
        logic [XW-1:0]   xb;    // tiled-walk cell base
        logic [BW-1:0]   bk;    // bank, or pair base in the paired walk
        logic            ph;    // paired walk: second bank of the pair
        walk_e           walk;
    } ptr_t;

    ptr_t q, d;

    function automatic logic [BW-1:0] bank_inc(input logic [BW-1:0] b);
        return (b == BLAST) ? '0 : b + 1'b1;
    endfunction

    always_comb begin
        logic [BW:0] bsum;
        logic [XW:0] nbase;
        d     = q;
        bsum  = {1'b0, q.bk} + (BW+1)'(2);
        nbase = {1'b0, q.xb} + (XW+1)'(GRP);
        if (ld_sub || ld_x || ld_ram) begin
            d.ph = 1'b0;
            if (ld_sub) d.sub = sub_val;
            if (ld_x) begin
                d.x  = (x_val > XLAST) ? XLAST : x_val;
                d.xb = (x_val > XLAST) ? XLAST : x_val;
            end
            if (ld_ram) begin
                d.bk   = bank_val;
                d.walk = decode_walk(mode_val);
            end
        end else if (adv) begin
            case (q.walk)
                WALK_PAIR: begin
                    d.ph = ~q.ph;
                    if (q.ph) begin
                        if (q.x == XLAST) begin
                            d.x = '0;
                            if (bsum >= (BW+1)'(NBANK)) begin
                                d.bk  = BW'(bsum - (BW+1)'(NBANK));
                                d.sub = q.sub + 1'b1;
                            end else begin
                                d.bk = BW'(bsum);
                            end
                        end else begin
                            d.x = q.x + 1'b1;
                        end
                    end
                end
                WALK_TILE: begin
                    if ((q.x - q.xb) != XW'(GRP - 1) && q.x != XLAST) begin
                        d.x = q.x + 1'b1;
                    end else if (q.bk != BLAST) begin
                        d.bk = q.bk + 1'b1;
                        d.x  = q.xb;
                    end else begin
                        d.bk = '0;
                        if (nbase >= (XW+1)'(NCOL)) begin
                            d.xb  = '0;
                            d.x   = '0;
                            d.sub = q.sub + 1'b1;
                        end else begin
                            d.xb = XW'(nbase);
                            d.x  = XW'(nbase);
                        end
                    end
                end
                default: begin
                    if (q.x == XLAST) begin
                        d.x = '0;
                        if (q.bk == BLAST) begin
                            d.bk  = '0;
                            d.sub = q.sub + 1'b1;
                        end else begin
                            d.bk = q.bk + 1'b1;
                        end
                    end else begin
                        d.x = q.x + 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.sub  <= '0;
            q.x    <= '0;
            q.xb   <= '0;
            q.bk   <= '0;
            q.ph   <= 1'b0;
            q.walk <= WALK_LIN;
        end else begin
            q <= d;
        end
    end

    assign sub_o  = q.sub;
    assign x_o    = q.x;
    assign bank_o = (q.walk == WALK_PAIR && q.ph) ? bank_inc(q.bk) : q.bk;
endmodule

// File: rtl/disp_addr_seq.sv
module disp_addr_seq #(
    parameter int NCOL  = 40,
    parameter int NBANK = 4,
    parameter int SUBW  = 4,
    parameter int GRP   = 8,
    localparam int XW   = $clog2(NCOL),
    localparam int BW   = $clog2(NBANK),
    localparam int AW   = $clog2(NCOL * NBANK)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [SUBW-1:0] pin_sub,
    input  logic            ld_sub,
    input  logic [SUBW-1:0] sub_val,
    input  logic            ld_x,
    input  logic [XW-1:0]   x_val,
    input  logic            ld_ram,
    input  logic [BW-1:0]   bank_val,
    input  logic [1:0]      mode_val,
    input  logic            byte_stb,
    input  logic            byte_wr,
    output logic [SUBW-1:0] cur_sub,
    output logic [XW-1:0]   cur_x,
    output logic [BW-1:0]   cur_bank,
    output logic [AW-1:0]   mem_addr,
    output logic            dev_sel,
    output logic            wr_en,
    output logic            rd_valid
);
    dap_ptr #(.NCOL(NCOL), .NBANK(NBANK), .SUBW(SUBW), .GRP(GRP)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .ld_sub   (ld_sub),
        .sub_val  (sub_val),
        .ld_x     (ld_x),
        .x_val    (x_val),
        .ld_ram   (ld_ram),
        .bank_val (bank_val),
        .mode_val (mode_val),
        .adv      (byte_stb),
        .sub_o    (cur_sub),
        .x_o      (cur_x),
        .bank_o   (cur_bank)
    );

    dap_gate #(.SUBW(SUBW)) u_gate (
        .pin_sub  (pin_sub),
        .cur_sub  (cur_sub),
        .byte_stb (byte_stb),
        .byte_wr  (byte_wr),
        .dev_sel  (dev_sel),
        .wr_en    (wr_en),
        .rd_valid (rd_valid)
    );

    assign mem_addr = AW'(cur_bank) * AW'(NCOL) + AW'(cur_x);
endmodule

// File: rtl/dap_chk.sv
module dap_chk #(
    parameter int NCOL = 40,
    parameter int SUBW = 4,
    parameter int XW   = 6,
    parameter int BW   = 2
) (
    input logic            clk,
    input logic            rst,
    input logic [SUBW-1:0] pin_sub,
    input logic            ld_sub,
    input logic            ld_x,
    input logic            ld_ram,
    input logic [XW-1:0]   x_val,
    input logic            byte_stb,
    input logic            byte_wr,
    input logic [SUBW-1:0] cur_sub,
    input logic [XW-1:0]   cur_x,
    input logic [BW-1:0]   cur_bank,
    input logic            wr_en,
    input logic            rd_valid
);
    // R7
    wr_gated_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (byte_stb && byte_wr && cur_sub == pin_sub));

    // R7
    rd_gated_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (byte_stb && !byte_wr && cur_sub == pin_sub));

    // R8
    adv_moves_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_stb && !ld_sub && !ld_x && !ld_ram) |=> !$stable({cur_sub, cur_x, cur_bank}));

    // R2
    x_load_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_x && x_val < XW'(NCOL)) |=> cur_x == $past(x_val));

    // R6
    sub_step_chk: assert property (@(posedge clk) disable iff (rst)
        !ld_sub |=> (cur_sub == $past(cur_sub) || cur_sub == SUBW'($past(cur_sub) + 1'b1)));

    // R3
    x_range_chk: assert property (@(posedge clk) disable iff (rst)
        cur_x < XW'(NCOL));
endmodule

bind disp_addr_seq dap_chk #(.NCOL(NCOL), .SUBW(SUBW), .XW(XW), .BW(BW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .pin_sub  (pin_sub),
    .ld_sub   (ld_sub),
    .ld_x     (ld_x),
    .ld_ram   (ld_ram),
    .x_val    (x_val),
    .byte_stb (byte_stb),
    .byte_wr  (byte_wr),
    .cur_sub  (cur_sub),
    .cur_x    (cur_x),
    .cur_bank (cur_bank),
    .wr_en    (wr_en),
    .rd_valid (rd_valid)
);

// File: tb/sim_disp_addr_seq.sv
module sim_disp_addr_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] pin_sub = 4'd15;
    logic       ld_sub = 0, ld_x = 0, ld_ram = 0, byte_stb = 0, byte_wr = 0;
    logic [3:0] sub_val = 0;
    logic [5:0] x_val = 0;
    logic [1:0] bank_val = 0, mode_val = 0;
    logic [3:0] cur_sub;
    logic [5:0] cur_x;
    logic [1:0] cur_bank;
    logic [7:0] mem_addr;
    logic       dev_sel, wr_en, rd_valid;

    int n_cmp = 0, n_bad = 0, cycles = 0;
    bit go = 0;
    bit done = 0;
    string tag = "R1";

    // reference model state
    int m_sub = 0, m_x = 0, m_xb = 0, m_bk = 0, m_ph = 0, m_walk = 2;

    always #2 clk = ~clk;

    disp_addr_seq u0 (.*);

    always @(posedge clk) begin
        cycles++;
        go = 1;
        if (rst) begin
            m_sub = 0; m_x = 0; m_xb = 0; m_bk = 0; m_ph = 0; m_walk = 2;
        end else if (ld_sub || ld_x || ld_ram) begin
            m_ph = 0;
            if (ld_sub) m_sub = sub_val;
            if (ld_x) begin m_x = (x_val > 39) ? 39 : x_val; m_xb = m_x; end
            if (ld_ram) begin m_bk = bank_val; m_walk = (mode_val == 3) ? 2 : mode_val; end
        end else if (byte_stb) begin
            if (m_walk == 2) begin
                m_x++;
                if (m_x == 40) begin m_x = 0; m_bk++; end
                if (m_bk == 4) begin m_bk = 0; m_sub = (m_sub + 1) % 16; end
            end else if (m_walk == 1) begin
                if (m_ph == 0) m_ph = 1;
                else begin
                    m_ph = 0; m_x++;
                    if (m_x == 40) begin
                        m_x = 0; m_bk += 2;
                        if (m_bk >= 4) begin m_bk -= 4; m_sub = (m_sub + 1) % 16; end
                    end
                end
            end else begin
                if (m_x - m_xb < 7 && m_x < 39) m_x++;
                else if (m_bk < 3) begin m_bk++; m_x = m_xb; end
                else begin
                    m_bk = 0; m_xb += 8;
                    if (m_xb >= 40) begin m_xb = 0; m_sub = (m_sub + 1) % 16; end
                    m_x = m_xb;
                end
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        #1;
        if (go && !done) begin
            automatic int eb = (m_walk == 1 && m_ph == 1) ? (m_bk + 1) % 4 : m_bk;
            automatic int sel = (m_sub == pin_sub) ? 1 : 0;
            chk({tag, " sub"}, cur_sub, m_sub);
            chk({tag, " x"}, cur_x, m_x);
            chk({tag, " bank"}, cur_bank, eb);
            chk("R10 mem_addr", mem_addr, eb * 40 + m_x);
            chk("R7 dev_sel", dev_sel, sel);
            chk("R7 wr_en", wr_en, (byte_stb && byte_wr) ? sel : 0);
            chk("R7 rd_valid", rd_valid, (byte_stb && !byte_wr) ? sel : 0);
        end
    end

    task automatic cyc(input bit ls, input int sv, input bit lx, input int xv,
                       input bit lr, input int bv, input int mv, input bit st, input bit wr);
        @(negedge clk);
        ld_sub = ls; sub_val = 4'(sv); ld_x = lx; x_val = 6'(xv);
        ld_ram = lr; bank_val = 2'(bv); mode_val = 2'(mv); byte_stb = st; byte_wr = wr;
    endtask

    task automatic setup(input int sv, input int xv, input int bv, input int mv);
        cyc(1, sv, 1, xv, 1, bv, mv, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic bytes(input int n, input bit wr);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 1, wr);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic finish_run();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        tag = "R1 reset";
        repeat (3) @(negedge clk);
        rst = 0;
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
        tag = "R3 R6 linear";
        setup(14, 30, 2, 2);
        bytes(2 * 160 + 40, 1);
        tag = "R4 R6 paired";
        pin_sub = 4'd3;
        setup(2, 37, 2, 1);
        bytes(20, 1);
        setup(15, 38, 2, 1);
        bytes(200, 0);
        tag = "R5 R6 tiled";
        setup(3, 24, 0, 0);
        bytes(80, 1);
        setup(7, 3, 1, 0);
        bytes(170, 0);
        tag = "R9 code3";
        setup(3, 38, 3, 3);
        bytes(10, 1);
        tag = "R2 R8 load priority";
        cyc(1, 9, 1, 63, 1, 1, 1, 1, 1);
        cyc(0, 0, 1, 5, 0, 0, 0, 1, 0);
        cyc(0, 0, 0, 0, 1, 0, 0, 1, 1);
        bytes(12, 1);
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        wait (cycles > 100000);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
        finish_run();
    end
endmodule